// File: doc/BRIEF.md
# I2C Register Control Port Target

This block is an I2C target that lets a host read and write a small bank of 8-bit control registers. It uses the two bus wires only. SCL is an input. SDA is an input that is sampled, plus an output enable that pulls the line low. Both wires pass through two synchroniser flops on the system clock before START, STOP and clock edges are detected. The seven-bit target address has a fixed upper part, `10011` by default. The two low bits come from a pair of strap pins, which are captured only while the block is held in reset.

A write transfer is sent as follows: address with the direction bit low, then a pointer byte, then any number of data bytes. Each data byte lands at the pointer, and the pointer then steps up by one. A read transfer streams bytes out starting at the current pointer, and the pointer steps up after each byte. The host ends a read burst by returning NACK. A repeated START keeps the pointer. This lets a host write just the pointer byte, issue a repeated START and then read from that register. When the address does not match, the target stays silent until the next START.

Top module: `i2c_reg_port`

## Requirements
- R1: An address byte whose upper seven bits equal `10011` followed by the captured strap values (first bit, then second bit) is acknowledged: the target pulls SDA low during the ninth SCL pulse. Bit 0 of that byte selects the direction, 1 for read and 0 for write.
- R2: An address byte that does not match gets no acknowledge. All following bytes up to the next START are neither acknowledged nor written, so the register contents are unchanged.
- R3: In a write transfer, the byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments by one.
- R4: In a read transfer, the target sends the register at the pointer, MSB first, and increments the pointer after each byte it sends.
- R5: Every byte the target receives in a matched transfer (address, pointer, data) is acknowledged by pulling SDA low during the ninth SCL pulse.
- R6: After the host returns NACK (SDA high) on a read byte, the target releases SDA and drives nothing until a START or STOP.
- R7: A repeated START returns the target to address reception and keeps the pointer.
- R8: The strap pins are captured only during reset. A change on them afterwards does not change the address the target answers to.
- R9: Only the low log2(NUM_REGS) bits of the pointer byte are used (bank of 16 by default), and the pointer wraps from the last register to register 0.
- R10: After reset, SDA is released and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset; strap pins are captured while it is low |
| strapIn | input | 2 | Strap pins giving the two low address bits |
| sclIn | input | 1 | Bus clock as seen on the wire |
| sdaIn | input | 1 | Bus data as seen on the wire |
| sdaPullLow | output | 1 | When high, the target pulls SDA low |

## Verification
A change on SCL or SDA reaches the second synchroniser flop on the second system clock edge. The edge detector sees it in that cycle, so the output enable moves on the third edge after the change. An acknowledge or a data bit therefore appears on SDA three cycles after SCL falls, and register writes and pointer steps land on that same edge. The bench models the open-drain wire and changes SCL or SDA only every ten system clocks. It samples SDA in the middle of each SCL high phase, well after these three cycles, and confirms stored values by reading them back over the bus.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef struct packed {
    logic       ptrLoad;
    logic       wrEn;
    logic       rdAdvance;
    logic [7:0] rxByte;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_WAIT
  } state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } phase_t;

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
  import i2cr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [6:0] devAddr,
  input  logic [7:0] rdData,
  output strobe_t    strobe,
  output logic       sdaOe
);

  logic       sclPrev, sdaPrev;
  state_t     state;
  phase_t     phase;
  logic [3:0] bitCnt;
  logic [7:0] shiftIn;
  logic [7:0] txShift;
  logic       isRead;
  logic       hostAck;

  logic sclRise, sclFall, startDet, stopDet, busEvent, byteDone;

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign busEvent = startDet | stopDet;
  assign byteDone = (state == ST_RX) && sclFall && (bitCnt == 4'd8);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      state   <= ST_IDLE;
      phase   <= PH_ADDR;
      bitCnt  <= '0;
      shiftIn <= '0;
      txShift <= '0;
      isRead  <= 1'b0;
      hostAck <= 1'b0;
      sdaOe   <= 1'b0;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (startDet) begin
        state  <= ST_RX;
        phase  <= PH_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) begin
              shiftIn <= {shiftIn[6:0], sdaS};
              bitCnt  <= bitCnt + 4'd1;
            end else if (byteDone) begin
              if (phase == PH_ADDR) begin
                if (shiftIn[7:1] == devAddr) begin
                  state  <= ST_ACK;
                  sdaOe  <= 1'b1;
                  isRead <= shiftIn[0];
                  phase  <= PH_PTR;
                end else begin
                  state <= ST_WAIT;
                end
              end else begin
                state  <= ST_ACK;
                sdaOe  <= 1'b1;
                isRead <= 1'b0;
                phase  <= PH_DATA;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                state   <= ST_TX;
                txShift <= rdData;
                sdaOe   <= ~rdData[7];
              end else begin
                state <= ST_RX;
                sdaOe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                state <= ST_RACK;
                sdaOe <= 1'b0;
              end else begin
                txShift <= {txShift[6:0], 1'b0};
                sdaOe   <= ~txShift[6];
              end
              bitCnt <= bitCnt + 4'd1;
            end
          end
          ST_RACK: begin
            if (sclRise) begin
              hostAck <= ~sdaS;
            end else if (sclFall) begin
              if (hostAck) begin
                state   <= ST_TX;
                bitCnt  <= '0;
                txShift <= rdData;
                sdaOe   <= ~rdData[7];
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.rxByte    = shiftIn;
    strobe.ptrLoad   = byteDone && (phase == PH_PTR) && !busEvent;
    strobe.wrEn      = byteDone && (phase == PH_DATA) && !busEvent;
    strobe.rdAdvance = !busEvent && sclFall &&
                       (((state == ST_ACK) && isRead) ||
                        ((state == ST_RACK) && hostAck));
  end

  assert_silent_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT || state == ST_IDLE) |-> !sdaOe);

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ptrLoad, strobe.wrEn, strobe.rdAdvance}));

  assert_restart_rearms_R7: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_RX && phase == PH_ADDR && bitCnt == 4'd0));

  assert_nack_releases_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RACK && sclFall && !hostAck && !busEvent) |=> (!sdaOe && state == ST_WAIT));

  assert_ack_follows_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && phase != PH_ADDR && !busEvent) |=> sdaOe);

endmodule

// File: rtl/i2cr_regs.sv
module i2cr_regs
  import i2cr_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    strobe,
  output logic [7:0] rdData
);

  localparam int PTR_W = $clog2(NUM_REGS);

  logic [7:0]       bank [NUM_REGS];
  logic [PTR_W-1:0] ptr;

  assign rdData = bank[ptr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
      ptr <= '0;
    end else begin
      if (strobe.ptrLoad) ptr <= strobe.rxByte[PTR_W-1:0];
      if (strobe.wrEn) begin
        bank[ptr] <= strobe.rxByte;
        ptr       <= ptr + PTR_W'(1);
      end
      if (strobe.rdAdvance) ptr <= ptr + PTR_W'(1);
    end
  end

  assert_ptr_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ptrLoad |=> ptr == $past(strobe.rxByte[PTR_W-1:0]));

  assert_write_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (ptr == $past(ptr) + PTR_W'(1)) && (bank[$past(ptr)] == $past(strobe.rxByte)));

  assert_read_advance_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdAdvance |=> ptr == $past(ptr) + PTR_W'(1));

endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
  import i2cr_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b10011
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] strapIn,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow
);

  logic       sclS, sdaS;
  logic [1:0] strapQ;
  logic [7:0] rdData;
  strobe_t    strobe;

  always_ff @(posedge clk) begin
    if (!rstN) strapQ <= strapIn;
  end

  i2cr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));

  i2cr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));

  i2cr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .devAddr({ADDR_HI, strapQ}), .rdData(rdData),
    .strobe(strobe), .sdaOe(sdaPullLow));

  i2cr_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData));

  assert_strap_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(strapQ));

endmodule

// File: tb/i2c_reg_port_test.sv
`timescale 1ns/1ps
module i2c_reg_port_test;

  localparam int Q = 10;
  localparam logic [7:0] ADDR_W = 8'h9C;  // 1001110, write
  localparam logic [7:0] ADDR_R = 8'h9D;  // 1001110, read

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] strapIn = 2'b10;
  logic sclLine = 1'b1;
  logic hostLow = 1'b0;
  logic sdaPullLow;
  wire  sdaLine = !(hostLow || sdaPullLow);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_reg_port uut (
    .clk(clk), .rstN(rstN), .strapIn(strapIn),
    .sclIn(sclLine), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitCycle(input bit drive, output bit seen);
    hostLow = !drive; wq();
    sclLine = 1'b1;   wq();
    seen = sdaLine;   wq();
    sclLine = 1'b0;   wq();
  endtask

  task automatic busStart();
    hostLow = 1'b0; wq();
    sclLine = 1'b1; wq();
    hostLow = 1'b1; wq();
    sclLine = 1'b0; wq();
  endtask

  task automatic busStop();
    hostLow = 1'b1; wq();
    sclLine = 1'b1; wq();
    hostLow = 1'b0; wq();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], s);
    bitCycle(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bitCycle(1'b1, s);
      b[i] = s;
    end
    bitCycle(!giveAck, s);
  endtask

  task automatic readRegs(input logic [7:0] ptrByte, input int n, input logic [7:0] exp [4], input string req);
    bit a;
    logic [7:0] d;
    busStart();
    sendByte(ADDR_W, a); check(a, "R1", a, 1);
    sendByte(ptrByte, a); check(a, "R5", a, 1);
    busStart();
    sendByte(ADDR_R, a); check(a, "R7", a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, d);
      check(d == exp[i], req, d, exp[i]);
    end
    busStop();
  endtask

  task automatic testReset();
    logic [7:0] e [4];
    check(sdaPullLow == 1'b0, "R10", sdaPullLow, 0);
    e = '{8'h00, 8'h00, 8'h00, 8'h00};
    readRegs(8'h00, 4, e, "R10");
  endtask

  task automatic testWrite();
    bit a;
    logic [7:0] e [4];
    busStart();
    sendByte(ADDR_W, a); check(a, "R1", a, 1);
    sendByte(8'h03, a);  check(a, "R5", a, 1);
    sendByte(8'hA5, a);  check(a, "R5", a, 1);
    sendByte(8'h3C, a);  check(a, "R5", a, 1);
    sendByte(8'h7E, a);  check(a, "R5", a, 1);
    busStop();
    e = '{8'hA5, 8'h3C, 8'h7E, 8'h00};
    readRegs(8'h03, 4, e, "R3");
  endtask

  task automatic testReadNack();
    bit a;
    logic [7:0] d;
    busStart();
    sendByte(ADDR_W, a);
    sendByte(8'h04, a);
    busStart();
    sendByte(ADDR_R, a);
    recvByte(1'b1, d); check(d == 8'h3C, "R4", d, 8'h3C);
    recvByte(1'b0, d); check(d == 8'h7E, "R4", d, 8'h7E);
    wq();
    check(sdaPullLow == 1'b0, "R6", sdaPullLow, 0);
    sclLine = 1'b1; wq();
    check(sdaPullLow == 1'b0, "R6", sdaPullLow, 0);
    sclLine = 1'b0; wq();
    check(sdaPullLow == 1'b0, "R6", sdaPullLow, 0);
    busStop();
  endtask

  task automatic testMismatch();
    bit a;
    logic [7:0] e [4];
    busStart();
    sendByte(8'h9E, a); check(!a, "R2", a, 0);
    sendByte(8'h03, a); check(!a, "R2", a, 0);
    sendByte(8'hFF, a); check(!a, "R2", a, 0);
    busStop();
    busStart();
    sendByte(8'h9A, a); check(!a, "R8", a, 0);
    busStop();
    e = '{8'hA5, 8'h3C, 8'h00, 8'h00};
    readRegs(8'h03, 2, e, "R2");
  endtask

  task automatic testWrap();
    bit a;
    logic [7:0] e [4];
    busStart();
    sendByte(ADDR_W, a); check(a, "R8", a, 1);
    sendByte(8'h0F, a);
    sendByte(8'h11, a);
    sendByte(8'h22, a);
    busStop();
    e = '{8'h11, 8'h22, 8'h00, 8'h00};
    readRegs(8'h0F, 2, e, "R9");
    e = '{8'hA5, 8'h3C, 8'h7E, 8'h00};
    readRegs(8'h13, 3, e, "R9");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    strapIn = 2'b01;
    wq();
    testReset();
    testWrite();
    testReadNack();
    testMismatch();
    testWrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule